// File: doc/BRIEF.md
# Battery Charge Mode Controller

This block is the digital sequencer for a single-cell charger that drives an external pass transistor. It takes comparator results that are already digitized: adapter voltage against battery voltage at two margins, battery voltage against four levels, and charge-current sense voltage against the termination level. From these it decides whether an adapter is present, which charge phase applies, whether the pass device is driven on, and whether the current limit uses the low (trickle) or the full sense threshold.

In hardware mode (charge-control input low) the block steps on its own from trickle to constant current, then to constant voltage, then to an end-of-charge hold. It re-enters constant current when the battery sags below the end-of-charge reset level. In processor mode (charge-control input high) the hardware sequence is parked and the processor's gate input drives the pass gate directly, so software can pulse-charge other chemistries. Trickle charging of a battery below the lockout level stays under hardware control in either mode. Adapter removal is filtered by a programmable off delay that stands in for a capacitor-set delay.

Top module: `chg_mode_ctrl`

## Requirements
- R1: With no adapter latched, a high `adp_attach` at a clock edge latches adapter presence. If `bat_lock` is high, `chg_det` is high from that edge on.
- R2: `chg_det` is low in every cycle in which `bat_lock` is low, whether or not an adapter is latched.
- R3: Once latched, presence ends only after `adp_hold` has been low at OFF_DLY consecutive clock edges. Any edge with `adp_hold` high restarts the count, and `adp_attach` has no effect while presence is latched.
- R4: With presence latched and `bat_lock` low, `mode` becomes 1 (trickle) at the next edge, whatever `proc_mode` is. In trickle, `ilim_full` is 0 and `gate_drv` is 0 (pass device on).
- R5: With presence latched, `bat_lock` high and `proc_mode` low, `mode` moves from idle (0) or trickle (1) to 2 (constant current) at the next edge. In that state `ilim_full` is 1 and `gate_drv` is 0.
- R6: From constant current, `bat_cv` high at an edge moves `mode` to 3 (constant voltage). `gate_drv` stays 0.
- R7: From constant voltage, an edge with `bat_eoc_qual` high and `sns_above_term` low moves `mode` to 4 (done). While `mode` is 4, `eoc` is 1 and `gate_drv` is 1 (pass device off).
- R8: `mode` stays at 4 while `bat_eoc_rst` is high. An edge with `bat_eoc_rst` low returns it to 2, and `eoc` then reads 0.
- R9: With `proc_mode` high and `mode` not 1, `gate_drv` equals `proc_gate` in the same cycle. With presence latched and `bat_lock` high, `mode` goes to 0 at the next edge, so `eoc` reads 0.
- R10: When presence ends, `mode` is 0 after the following edge. `ilim_full` is 0 from the cycle in which presence ends. With `proc_mode` low, `gate_drv` is then 1.
- R11: During and after reset, `mode` is 0, `chg_det` and `eoc` are 0, `ilim_full` is 0, and `gate_drv` is 1 while `proc_mode` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adp_attach | input | 1 | Adapter above battery by the larger (attach) margin |
| adp_hold | input | 1 | Adapter above battery by the smaller (release) margin |
| bat_lock | input | 1 | Battery above the undervoltage-lockout level |
| bat_eoc_rst | input | 1 | Battery above the end-of-charge reset level (about 3.96 V) |
| bat_eoc_qual | input | 1 | Battery above the end-of-charge qualify level (about 4.0 V) |
| bat_cv | input | 1 | Battery at or above the constant-voltage level (4.2 V) |
| sns_above_term | input | 1 | Sense voltage above the termination level (14 mV) |
| proc_mode | input | 1 | Processor charge control: 0 hardware sequence, 1 processor gate control |
| proc_gate | input | 1 | Processor gate level, used in processor mode |
| chg_det | output | 1 | Charger detected (adapter present and battery above lockout) |
| eoc | output | 1 | End of charge reached |
| gate_drv | output | 1 | Pass-gate level: 1 device off, 0 device on |
| ilim_full | output | 1 | Current limit select: 1 full (160 mV), 0 trickle (20 mV) |
| mode | output | 3 | Charge phase: 0 idle, 1 trickle, 2 constant current, 3 constant voltage, 4 done |

## Verification
On every cycle the assertions check that charger-detect is never high below lockout, that trickle drives the pass device on at the low limit, and that processor mode passes the gate input straight through. They also check that done keeps the gate off, that constant voltage is only entered from constant current, and that idle follows loss of presence. The exact length of the off delay, the restart of that delay by a brief return of the release flag, and the ordering of the full trickle to done to recharge cycle can only be shown by the bench's directed scenarios. The random runs then check every output against the bench's own model over long mixes of adapter, battery and processor activity.

// File: rtl/chg_pkg.sv
package chg_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE    = 3'd0,
    MODE_TRICKLE = 3'd1,
    MODE_CC      = 3'd2,
    MODE_CV      = 3'd3,
    MODE_DONE    = 3'd4
  } chg_mode_e;

  typedef struct packed {
    logic lock;      // above undervoltage lockout
    logic eoc_rst;   // above end-of-charge reset level
    logic eoc_qual;  // above end-of-charge qualify level
    logic cv;        // at constant-voltage level
  } bat_flags_t;

  // Phase sequencing: presence first, then lockout, then processor park,
  // then the hardware charge ladder.
  function automatic chg_mode_e next_mode(
    input chg_mode_e  cur,
    input logic       present,
    input bat_flags_t bat,
    input logic       sns_above_term,
    input logic       proc_mode
  );
    chg_mode_e nxt;
    nxt = cur;
    if (!present) begin
      nxt = MODE_IDLE;
    end else if (!bat.lock) begin
      nxt = MODE_TRICKLE;
    end else if (proc_mode) begin
      nxt = MODE_IDLE;
    end else begin
      unique case (cur)
        MODE_IDLE, MODE_TRICKLE: nxt = MODE_CC;
        MODE_CC:   nxt = bat.cv ? MODE_CV : MODE_CC;
        MODE_CV:   nxt = (bat.eoc_qual && !sns_above_term) ? MODE_DONE : MODE_CV;
        MODE_DONE: nxt = bat.eoc_rst ? MODE_DONE : MODE_CC;
        default:   nxt = MODE_IDLE;
      endcase
    end
    return nxt;
  endfunction

  // Gate level: 1 keeps the pass device off.
  function automatic logic gate_level(
    input chg_mode_e cur,
    input logic      proc_mode,
    input logic      proc_gate
  );
    logic g;
    if (cur == MODE_TRICKLE)   g = 1'b0;
    else if (proc_mode)        g = proc_gate;
    else if (cur == MODE_CC || cur == MODE_CV) g = 1'b0;
    else                       g = 1'b1;
    return g;
  endfunction

  function automatic logic full_limit(input chg_mode_e cur, input logic present);
    return present && (cur != MODE_TRICKLE);
  endfunction

endpackage

// File: rtl/chg_presence.sv
module chg_presence #(
  parameter int OFF_DLY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adp_attach,
  input  logic adp_hold,
  output logic present,
  output logic drop_evt
);
  localparam int CW = (OFF_DLY < 2) ? 1 : $clog2(OFF_DLY);
  localparam logic [CW-1:0] LAST = CW'(OFF_DLY - 1);

  logic [CW-1:0] low_cnt;
  logic          on_q;

  assign drop_evt = on_q && !adp_hold && (low_cnt == LAST);
  assign present  = on_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q    <= 1'b0;
      low_cnt <= '0;
    end else if (!on_q) begin
      low_cnt <= '0;
      if (adp_attach) on_q <= 1'b1;
    end else if (adp_hold) begin
      low_cnt <= '0;
    end else if (drop_evt) begin
      on_q    <= 1'b0;
      low_cnt <= '0;
    end else begin
      low_cnt <= low_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/chg_seq.sv
module chg_seq
  import chg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       present,
  input  bat_flags_t bat,
  input  logic       sns_above_term,
  input  logic       proc_mode,
  output chg_mode_e  mode,
  output logic       done_entry
);
  chg_mode_e mode_q;
  chg_mode_e mode_d;

  always_comb begin
    mode_d = next_mode(mode_q, present, bat, sns_above_term, proc_mode);
  end

  assign done_entry = (mode_d == MODE_DONE) && (mode_q != MODE_DONE);
  assign mode       = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_IDLE;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/chg_outdec.sv
module chg_outdec
  import chg_pkg::*;
(
  input  chg_mode_e mode,
  input  logic      present,
  input  logic      bat_lock,
  input  logic      proc_mode,
  input  logic      proc_gate,
  output logic      chg_det,
  output logic      eoc,
  output logic      gate_drv,
  output logic      ilim_full
);
  always_comb begin
    chg_det   = present && bat_lock;
    eoc       = (mode == MODE_DONE);
    gate_drv  = gate_level(mode, proc_mode, proc_gate);
    ilim_full = full_limit(mode, present);
  end
endmodule

// File: rtl/chg_mode_ctrl.sv
module chg_mode_ctrl
  import chg_pkg::*;
#(
  parameter int OFF_DLY = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adp_attach,
  input  logic       adp_hold,
  input  logic       bat_lock,
  input  logic       bat_eoc_rst,
  input  logic       bat_eoc_qual,
  input  logic       bat_cv,
  input  logic       sns_above_term,
  input  logic       proc_mode,
  input  logic       proc_gate,
  output logic       chg_det,
  output logic       eoc,
  output logic       gate_drv,
  output logic       ilim_full,
  output logic [2:0] mode
);
  logic       present_w;
  logic       drop_w;
  logic       done_entry_w;
  bat_flags_t bat_w;
  chg_mode_e  mode_w;

  assign bat_w = '{lock: bat_lock, eoc_rst: bat_eoc_rst,
                   eoc_qual: bat_eoc_qual, cv: bat_cv};

  chg_presence #(.OFF_DLY(OFF_DLY)) u_pres (
    .clk        (clk),
    .rst_n      (rst_n),
    .adp_attach (adp_attach),
    .adp_hold   (adp_hold),
    .present    (present_w),
    .drop_evt   (drop_w)
  );

  chg_seq u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .present        (present_w),
    .bat            (bat_w),
    .sns_above_term (sns_above_term),
    .proc_mode      (proc_mode),
    .mode           (mode_w),
    .done_entry     (done_entry_w)
  );

  chg_outdec u_out (
    .mode      (mode_w),
    .present   (present_w),
    .bat_lock  (bat_lock),
    .proc_mode (proc_mode),
    .proc_gate (proc_gate),
    .chg_det   (chg_det),
    .eoc       (eoc),
    .gate_drv  (gate_drv),
    .ilim_full (ilim_full)
  );

  assign mode = mode_w;
endmodule

// File: rtl/chg_mode_ctrl_chk.sv
module chg_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       present,
  input logic       drop_evt,
  input logic       done_entry,
  input logic       adp_attach,
  input logic       bat_lock,
  input logic       proc_mode,
  input logic       proc_gate,
  input logic       chg_det,
  input logic       gate_drv,
  input logic       ilim_full,
  input logic [2:0] mode
);
  AST_DET_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    chg_det |-> bat_lock); // R2

  AST_ATTACH_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!present && adp_attach) |=> present); // R1

  AST_DROP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> !present); // R3

  AST_TRICKLE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1) |-> (!ilim_full && !gate_drv)); // R4

  AST_CV_AFTER_CC: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && $past(mode) != 3'd3) |-> ($past(mode) == 3'd2)); // R6

  AST_DONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    done_entry |=> (mode == 3'd4)); // R7

  AST_DONE_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && !proc_mode) |-> gate_drv); // R7

  AST_PROC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_mode && mode != 3'd1) |-> (gate_drv == proc_gate)); // R9

  AST_IDLE_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(present) |=> (mode == 3'd0)); // R10

  AST_LIMIT_NEEDS_PRES: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_full |-> present); // R10
endmodule

bind chg_mode_ctrl chg_mode_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .present    (present_w),
  .drop_evt   (drop_w),
  .done_entry (done_entry_w),
  .adp_attach (adp_attach),
  .bat_lock   (bat_lock),
  .proc_mode  (proc_mode),
  .proc_gate  (proc_gate),
  .chg_det    (chg_det),
  .gate_drv   (gate_drv),
  .ilim_full  (ilim_full),
  .mode       (mode)
);

// File: tb/chg_mode_ctrl_test.sv
`timescale 1ns/1ps
module chg_mode_ctrl_test;
  localparam int DLY = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adp_attach = 0, adp_hold = 0;
  logic bat_lock = 0, bat_eoc_rst = 0, bat_eoc_qual = 0, bat_cv = 0;
  logic sns_above_term = 1, proc_mode = 0, proc_gate = 0;
  logic chg_det, eoc, gate_drv, ilim_full;
  logic [2:0] mode;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  chg_mode_ctrl #(.OFF_DLY(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .adp_attach(adp_attach), .adp_hold(adp_hold),
    .bat_lock(bat_lock), .bat_eoc_rst(bat_eoc_rst), .bat_eoc_qual(bat_eoc_qual),
    .bat_cv(bat_cv), .sns_above_term(sns_above_term), .proc_mode(proc_mode),
    .proc_gate(proc_gate), .chg_det(chg_det), .eoc(eoc), .gate_drv(gate_drv),
    .ilim_full(ilim_full), .mode(mode)
  );

  // Bench model: presence with off-delay and a phase number.
  bit m_on = 0;
  int m_low = 0;
  int m_ph = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_on <= 0; m_low <= 0; m_ph <= 0;
    end else begin
      if (!m_on) begin
        m_low <= 0;
        m_on <= adp_attach;
      end else if (adp_hold) m_low <= 0;
      else if (m_low + 1 >= DLY) begin m_on <= 0; m_low <= 0; end
      else m_low <= m_low + 1;
      m_ph <= exp_next(m_ph);
    end
  end

  function automatic int exp_next(int ph);
    if (!m_on) return 0;
    if (!bat_lock) return 1;
    if (proc_mode) return 0;
    if (ph <= 1) return 2;
    if (ph == 2) return bat_cv ? 3 : 2;
    if (ph == 3) return (bat_eoc_qual && !sns_above_term) ? 4 : 3;
    return bat_eoc_rst ? 4 : 2;
  endfunction

  function automatic int exp_gate();
    case (m_ph)
      1: return 0;
      2, 3: return proc_mode ? int'(proc_gate) : 0;
      default: return proc_mode ? int'(proc_gate) : 1;
    endcase
  endfunction

  function automatic string req_of(int ph);
    case (ph)
      0: return "R10";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
    end
  endtask

  task automatic model_cmp();
    chk("R2", "chg_det model", int'(chg_det), int'(m_on && bat_lock));
    chk(req_of(m_ph), "mode model", int'(mode), m_ph);
    chk("R7", "eoc model", int'(eoc), int'(m_ph == 4));
    chk("R9", "gate model", int'(gate_drv), exp_gate());
    chk("R4", "ilim model", int'(ilim_full), int'(m_on && m_ph != 1));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
    model_cmp();
  endtask

  task automatic set_bat(int lev);
    bat_lock = lev >= 1; bat_eoc_rst = lev >= 2;
    bat_eoc_qual = lev >= 3; bat_cv = lev >= 4;
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lev;
    int adp;
    int unsigned seed_sink;
    seed_sink = $urandom(32'd4711);
    set_bat(0);
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "mode reset", int'(mode), 0);
    chk("R11", "chg_det reset", int'(chg_det), 0);
    chk("R11", "eoc reset", int'(eoc), 0);
    chk("R11", "gate reset", int'(gate_drv), 1);
    chk("R11", "ilim reset", int'(ilim_full), 0);
    rst_n = 1;

    // R2 / R4: adapter on a battery below lockout
    adp_attach = 1; adp_hold = 1;
    tick();
    chk("R2", "det below lockout", int'(chg_det), 0);
    tick();
    chk("R4", "trickle mode", int'(mode), 1);
    chk("R4", "trickle gate", int'(gate_drv), 0);
    chk("R4", "trickle limit", int'(ilim_full), 0);
    // R1 / R5: battery clears lockout
    set_bat(1); #1;
    chk("R1", "det above lockout", int'(chg_det), 1);
    tick();
    chk("R5", "cc mode", int'(mode), 2);
    chk("R5", "cc limit", int'(ilim_full), 1);
    chk("R5", "cc gate", int'(gate_drv), 0);
    // R6
    set_bat(4); tick();
    chk("R6", "cv mode", int'(mode), 3);
    chk("R6", "cv gate", int'(gate_drv), 0);
    // R7
    sns_above_term = 0; tick();
    chk("R7", "done mode", int'(mode), 4);
    chk("R7", "eoc high", int'(eoc), 1);
    chk("R7", "done gate", int'(gate_drv), 1);
    // R8
    sns_above_term = 1; set_bat(2); tick();
    chk("R8", "done holds", int'(mode), 4);
    set_bat(1); tick();
    chk("R8", "recharge mode", int'(mode), 2);
    chk("R8", "eoc cleared", int'(eoc), 0);
    // R9
    proc_mode = 1; proc_gate = 0; tick();
    chk("R9", "proc idle", int'(mode), 0);
    chk("R9", "proc gate low", int'(gate_drv), 0);
    proc_gate = 1; #1;
    chk("R9", "proc gate high", int'(gate_drv), 1);
    proc_mode = 0; tick();
    // R3: interrupted release keeps presence
    adp_attach = 0; adp_hold = 0;
    repeat (DLY - 1) tick();
    adp_hold = 1; tick();
    adp_hold = 0;
    repeat (DLY - 1) tick();
    chk("R3", "det after restart", int'(chg_det), 1);
    // R3 / R10: full release
    tick();
    chk("R3", "det dropped", int'(chg_det), 0);
    chk("R10", "limit on loss", int'(ilim_full), 0);
    tick();
    chk("R10", "idle after loss", int'(mode), 0);
    chk("R10", "gate after loss", int'(gate_drv), 1);

    // Random mix
    lev = 1; adp = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) begin
        lev = lev + (($urandom_range(1) == 1) ? 1 : -1);
        if (lev < 0) lev = 0;
        if (lev > 4) lev = 4;
      end
      if ($urandom_range(19) == 0) adp = $urandom_range(2);
      if ($urandom_range(49) == 0) proc_mode = ~proc_mode;
      set_bat(lev);
      adp_attach = (adp == 2);
      adp_hold = (adp >= 1);
      sns_above_term = ($urandom_range(3) != 0);
      proc_gate = $urandom_range(1);
      tick();
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule